// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block owns the program counter of a simple 32-bit in-order core and works out the next PC value in every cycle. It reads the current instruction word together with the two source register values that the register file has already delivered, and decides whether control flow continues in sequence, follows a conditional branch, or follows an unconditional jump. The PC advances on every rising clock edge for which the advance enable is high, and it stays put otherwise.

A conditional branch compares the two operands. It is either a branch-on-equal or a branch-on-differ. If the branch is taken, it lands relative to the address of the next sequential instruction, using a signed 16-bit word offset. A jump builds its target from a 26-bit word index in the instruction. The top four bits of that target come from the sequential address. A combinational taken flag shows, for the instruction now presented, whether the block will redirect control flow.

Top module: `pc_sequencer`

## Requirements
- R1: While rst_n is low at a rising clock edge, the PC loads the RESET_PC parameter at that edge, whatever the state of adv_en.
- R2: While adv_en is low at a rising edge and rst_n is high, the PC keeps its value.
- R3: An opcode (instr[31:26]) other than 2, 4 or 5 advances the PC by 4 and drives redirect low.
- R4: Opcode 4 (branch-on-equal) with src_a equal to src_b loads PC + 4 + (sign-extended instr[15:0] * 4) and drives redirect high.
- R5: Opcode 4 with src_a different from src_b advances the PC by 4 and drives redirect low.
- R6: Opcode 5 (branch-on-differ) is taken with the same target rule when src_a differs from src_b, and otherwise advances by 4 with redirect low.
- R7: A negative branch offset moves the PC backwards, and the target is computed modulo 2^32. A branch may therefore cross a 256 MB region boundary.
- R8: Opcode 2 (jump) always loads {PCplus4[31:28], instr[25:0], 2'b00} and drives redirect high.
- R9: The four upper bits of a jump target come from PC + 4, not from PC. A jump placed in the last word of a 256 MB region therefore lands in the following region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| adv_en | input | 1 | PC update enable |
| instr | input | 32 | Current instruction word |
| src_a | input | 32 | First register operand of a branch compare |
| src_b | input | 32 | Second register operand of a branch compare |
| pc | output | 32 | Current program counter |
| redirect | output | 1 | High when the presented instruction will redirect flow |

## Verification
The block's only state is the PC, so any fault in it shows on the pc port at the clock edge right after the offending instruction is presented. A wrong sequential increment, a wrong offset scale or a wrong sign extension therefore shows within one cycle. A fault in the compare or the opcode decode shows at once on redirect, before the edge, and then as a wrong PC after the edge. A fault in how the upper jump bits are sourced shows only when PC and PC + 4 differ in their top four bits. For that reason the bench steers the PC onto a 256 MB region boundary before it tests that case.

// File: rtl/pcseq_pkg.sv
// Shared types for the next-PC unit: flow-control kind and opcode values.
package pcseq_pkg;
    typedef enum logic [1:0] {
        FLOW_SEQ   = 2'd0,
        FLOW_BREQ  = 2'd1,
        FLOW_BRNE  = 2'd2,
        FLOW_JUMP  = 2'd3
    } flow_e;

    localparam logic [5:0] OPC_JUMP = 6'd2;
    localparam logic [5:0] OPC_BREQ = 6'd4;
    localparam logic [5:0] OPC_BRNE = 6'd5;
endpackage

// File: rtl/pcseq_decode.sv
// Classifies the instruction by its opcode and resolves whether it redirects.
// Assumes the operands are valid in the same cycle as the instruction.
module pcseq_decode
    import pcseq_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int OPC_LO = 26
) (
    input  logic [XLEN-1:0] instr,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    output flow_e           kind,
    output logic            taken
);
    logic [5:0] opc;
    logic       same;

    assign opc  = instr[OPC_LO +: 6];
    assign same = (src_a == src_b);

    // Map opcode to flow kind.
    always_comb begin
        unique case (opc)
            OPC_JUMP: kind = FLOW_JUMP;
            OPC_BREQ: kind = FLOW_BREQ;
            OPC_BRNE: kind = FLOW_BRNE;
            default:  kind = FLOW_SEQ;
        endcase
    end

    // Decide whether the flow kind leaves the sequential path.
    always_comb begin
        unique case (kind)
            FLOW_JUMP: taken = 1'b1;
            FLOW_BREQ: taken = same;
            FLOW_BRNE: taken = !same;
            default:   taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/pcseq_target.sv
// Forms the sequential, branch and jump addresses and selects the next PC.
// Assumes instructions are word aligned, so offsets and indices are word counts.
module pcseq_target
    import pcseq_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int OFS_W   = 16,
    parameter int IDX_W   = 26
) (
    input  logic [XLEN-1:0] pc_cur,
    input  logic [XLEN-1:0] instr,
    input  flow_e           kind,
    input  logic            taken,
    output logic [XLEN-1:0] pc_next
);
    localparam int STEP  = 4;
    localparam int HI_W  = XLEN - IDX_W - 2;

    logic [XLEN-1:0] seq_addr;
    logic [XLEN-1:0] br_disp;
    logic [XLEN-1:0] br_addr;
    logic [XLEN-1:0] jmp_addr;

    // Sequential address, sign-scaled branch displacement and targets.
    always_comb begin
        seq_addr = pc_cur + XLEN'(STEP);
        br_disp  = {{(XLEN-OFS_W-2){instr[OFS_W-1]}}, instr[OFS_W-1:0], 2'b00};
        br_addr  = seq_addr + br_disp;
        jmp_addr = {seq_addr[XLEN-1 -: HI_W], instr[IDX_W-1:0], 2'b00};
    end

    // Choose the next PC from the resolved flow kind.
    always_comb begin
        if (!taken)
            pc_next = seq_addr;
        else if (kind == FLOW_JUMP)
            pc_next = jmp_addr;
        else
            pc_next = br_addr;
    end
endmodule

// File: rtl/pcseq_reg.sv
// Holds the program counter; synchronous active-low reset to a vector.
module pcseq_reg #(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv_en,
    input  logic [XLEN-1:0] pc_next,
    output logic [XLEN-1:0] pc_q
);
    // Load the reset vector or advance when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= RESET_PC;
        else if (adv_en)
            pc_q <= pc_next;
    end
endmodule

// File: rtl/pc_sequencer.sv
// Top of the next-PC unit: decode, target selection and PC register.
// Assumes register operands are read in the same cycle as the instruction.
module pc_sequencer
    import pcseq_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        adv_en,
    input  logic [31:0] instr,
    input  logic [31:0] src_a,
    input  logic [31:0] src_b,
    output logic [31:0] pc,
    output logic        redirect
);
    localparam int XLEN = 32;

    flow_e           kind;
    logic            taken;
    logic [XLEN-1:0] pc_next;

    pcseq_decode #(.XLEN(XLEN), .OPC_LO(26)) u_dec (
        .instr (instr),
        .src_a (src_a),
        .src_b (src_b),
        .kind  (kind),
        .taken (taken)
    );

    pcseq_target #(.XLEN(XLEN), .OFS_W(16), .IDX_W(26)) u_tgt (
        .pc_cur  (pc),
        .instr   (instr),
        .kind    (kind),
        .taken   (taken),
        .pc_next (pc_next)
    );

    pcseq_reg #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_en  (adv_en),
        .pc_next (pc_next),
        .pc_q    (pc)
    );

    assign redirect = taken;
endmodule

// File: rtl/pc_sequencer_chk.sv
// Property checker for pc_sequencer, attached by bind.
module pc_sequencer_chk #(
    parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        adv_en,
    input logic [31:0] instr,
    input logic [31:0] src_a,
    input logic [31:0] src_b,
    input logic [31:0] pc,
    input logic        redirect
);
    logic rst_prev;

    // Remember whether reset was sampled low at the previous edge.
    always_ff @(posedge clk) rst_prev <= !rst_n;

    // R1: the edge after a low reset sample shows the reset vector.
    always @(posedge clk) begin
        if (rst_prev === 1'b1)
            p_reset_vec_r1: assert (pc == RESET_PC)
                else $error("R1 pc %h", pc);
    end

    // R2: a disabled cycle keeps the PC.
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_en |=> $stable(pc));

    // R3, R5: no redirect means a plain step of 4.
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_en && !redirect) |=> pc == $past(pc) + 32'd4);

    // R3: opcodes outside the control set never redirect.
    p_seq_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(instr[31:26] inside {6'd2, 6'd4, 6'd5}) |-> !redirect);

    // R8: jump fills the low 28 bits from the index.
    p_jump_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_en && instr[31:26] == 6'd2) |=>
            pc[27:0] == {$past(instr[25:0]), 2'b00});

    // R4: a taken branch-on-equal lands at the scaled offset past PC + 4.
    p_breq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_en && instr[31:26] == 6'd4 && src_a == src_b) |=>
            pc == $past(pc) + 32'd4
                  + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00});
endmodule

bind pc_sequencer pc_sequencer_chk #(.RESET_PC(RESET_PC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv_en   (adv_en),
    .instr    (instr),
    .src_a    (src_a),
    .src_b    (src_b),
    .pc       (pc),
    .redirect (redirect)
);

// File: tb/pc_sequencer_test.sv
`timescale 1ns/1ps
// Directed bench for pc_sequencer; one task per scenario.
module pc_sequencer_test;
    localparam logic [31:0] RV = 32'd80000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adv_en = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [31:0] pc;
    logic        redirect;

    int n_run = 0;
    int n_bad = 0;

    pc_sequencer #(.RESET_PC(RV)) uut (
        .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .instr(instr),
        .src_a(src_a), .src_b(src_b), .pc(pc), .redirect(redirect)
    );

    always #2.5 clk = ~clk;

    initial begin
        #100000;
        n_run++; n_bad++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    function automatic logic [31:0] ityp(input logic [5:0] op, input logic [15:0] ofs);
        return {op, 5'd9, 5'd10, ofs};
    endfunction

    function automatic logic [31:0] jtyp(input logic [25:0] idx);
        return {6'd2, idx};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Present one instruction; check redirect before the edge, pc after it.
    task automatic step(input string req, input logic [31:0] ins, input logic [31:0] a,
                        input logic [31:0] b, input logic exp_rd, input logic [31:0] exp_pc);
        @(negedge clk);
        instr = ins; src_a = a; src_b = b; adv_en = 1'b1;
        #1;
        chk(req, {31'd0, redirect}, {31'd0, exp_rd});
        @(posedge clk); #1;
        chk(req, pc, exp_pc);
    endtask

    task automatic t_reset;
        @(negedge clk); rst_n = 1'b0; adv_en = 1'b1; instr = jtyp(26'h123);
        @(posedge clk); #1;
        chk("R1", pc, RV);
        @(negedge clk); rst_n = 1'b1; adv_en = 1'b0;
    endtask

    task automatic t_hold;
        logic [31:0] keep;
        keep = pc;
        @(negedge clk); adv_en = 1'b0; instr = jtyp(26'h55);
        @(posedge clk); #1; chk("R2", pc, keep);
        @(posedge clk); #1; chk("R2", pc, keep);
    endtask

    task automatic t_seq;
        step("R3", 32'h0232_8820, 32'd1, 32'd2, 1'b0, RV + 32'd4);
        step("R3", ityp(6'd35, 16'h04B0), 32'd7, 32'd7, 1'b0, RV + 32'd8);
    endtask

    task automatic t_breq;
        // pc = 80008; reset to 80004 first via reset + one step
        t_reset();
        step("R3", 32'd0, 32'd0, 32'd0, 1'b0, 32'd80004);
        step("R4", ityp(6'd4, 16'd3), 32'hABCD, 32'hABCD, 1'b1, 32'd80020);
        step("R5", ityp(6'd4, 16'd3), 32'hABCD, 32'hABCE, 1'b0, 32'd80024);
    endtask

    task automatic t_brne;
        step("R6", ityp(6'd5, 16'd10), 32'd1, 32'd2, 1'b1, 32'd80024 + 32'd4 + 32'd40);
        step("R6", ityp(6'd5, 16'd10), 32'd9, 32'd9, 1'b0, 32'd80072);
    endtask

    task automatic t_jump_and_back;
        step("R8", jtyp(26'h3FF_FFFF), 32'd0, 32'd1, 1'b1, 32'h0FFF_FFFC);
        step("R9", jtyp(26'd5), 32'd0, 32'd0, 1'b1, 32'h1000_0014);
        step("R7", ityp(6'd5, 16'hFFFE), 32'd1, 32'd0, 1'b1, 32'h1000_0010);
        step("R3", 32'd0, 32'd0, 32'd0, 1'b0, 32'h1000_0014);
        step("R8", jtyp(26'd1), 32'd0, 32'd0, 1'b1, 32'h1000_0004);
        step("R7", ityp(6'd4, 16'hFFFD), 32'd3, 32'd3, 1'b1, 32'h0FFF_FFFC);
    endtask

    initial begin
        t_reset();
        t_seq();
        t_hold();
        t_breq();
        t_brne();
        t_jump_and_back();
        t_hold();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule